// File: doc/BRIEF.md
# Lane-Partitioned Multi-Operand Adder Tree

This block adds up to fifteen 16-bit words in a single pass and returns one 16-bit result. Two run-time cut inputs can split the word into independent lanes, one cut at bit 4 and one at bit 8. Each lane of the result is the sum of the matching lane of every operand, wrapped to the lane width. No carry ever crosses an active cut. It serves as the final summation stage of a partitioned multiplier, or as any packed multi-lane accumulator where the lane split changes from operation to operation.

The operand count is a parameter. The operands pass through levels of 3:2 carry-save compressors until two words remain. A two-input adder whose carry chain is cleared at each active cut then produces the result. Each compressor also clears the carries it would push across an active cut. A parameter mask places a pipeline register at any chosen subset of register points. Point k lies after k compressor levels, and the point one past the tree depth is the output register. The cut settings travel through the same registers as the data. A new operand set may be applied on every cycle.

Top module: `partAddTree`

## Requirements
- R1: While `rstN` is low, every pipeline register is cleared, so a configuration with at least one register point drives `sumOut` to 0.
- R2: With both cuts low, `sumOut` equals the sum of all operands modulo 2^16.
- R3: With only `cutLo` high, bits 3:0 of `sumOut` hold the sum of the operands' bits 3:0 modulo 16, and bits 15:4 hold the sum of their bits 15:4 modulo 2^12.
- R4: With only `cutHi` high, bits 7:0 and bits 15:8 of `sumOut` each hold the byte-wide sum of the matching operand bytes, wrapped to 8 bits.
- R5: With both cuts high, the lanes are bits 15:8, 7:4 and 3:0, each wrapped independently. No carry passes from bit 3 to bit 4 or from bit 7 to bit 8.
- R6: With `NUM_IN` = 0, `sumOut` is always 0 whatever `dataIn` carries. An all-zero operand set gives 0 in any configuration.
- R7: With `NUM_IN` = 1, `sumOut` equals the single operand under every cut setting.
- R8: The latency from `dataIn` to `sumOut` equals the number of bits set in `REG_MASK` at indices 0 to D+1. D is the compressor depth for `NUM_IN` operands, and bits above D+1 must be zero. A new operand set is accepted every cycle.
- R9: Each result uses the cut settings present in the same cycle as its operands, even when the cuts change on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rstN | input | 1 | Asynchronous active-low reset |
| cutLo | input | 1 | When high, separates bits 3:0 from bit 4 upward |
| cutHi | input | 1 | When high, separates bits 7:0 from bit 8 upward |
| dataIn | input | max(NUM_IN,1)*16 | Packed operands; operand i occupies bits 16*i+15 : 16*i |
| sumOut | output | 16 | Lane-partitioned sum |

## Verification
The checker relates `sumOut` to `dataIn` only after operands and cuts have stayed unchanged for as many cycles as the latency. Until then, results from earlier operands are still leaving the pipeline. It assumes `REG_MASK` has no bits set beyond the output register point, so the latency it derives is the real one. The stimulus holds a small number of configurations in which the mask stays within that range. Most cycles change inputs on every clock, so the assertions judge only the held stretches, such as the all-zero flush. The bench compares every cycle against arithmetic lane sums.

// File: rtl/addTreePkg.sv
package addTreePkg;

  localparam int WORD_W = 16;
  localparam int MASK_W = 8;

  // Per-level control strobes: one bit per position whose incoming carry is dropped
  typedef struct packed {
    logic [WORD_W-1:0] killMask;
  } ctlStrobe_t;

  // Operand slots at tree entry (at least two so the final adder always has inputs)
  function automatic int slotsOf(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  // Operand count after k compressor levels
  function automatic int opsAt(input int n, input int k);
    int c;
    c = slotsOf(n);
    for (int i = 0; i < k; i++) begin
      if (c > 2) c = (c / 3) * 2 + (c % 3);
    end
    return c;
  endfunction

  // Number of compressor levels needed to reach two operands
  function automatic int depthOf(input int n);
    int c;
    int d;
    c = slotsOf(n);
    d = 0;
    while (c > 2) begin
      c = (c / 3) * 2 + (c % 3);
      d++;
    end
    return d;
  endfunction

  // Clock latency: register points actually present in the tree
  function automatic int latencyOf(input int n, input logic [MASK_W-1:0] mask);
    int cnt;
    cnt = 0;
    for (int i = 0; i < MASK_W; i++) begin
      if (i <= depthOf(n) + 1 && mask[i]) cnt++;
    end
    return cnt;
  endfunction

  // Two-operand add whose carry chain is cleared at each killMask position
  function automatic logic [WORD_W-1:0] laneAdd(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b,
                                                input logic [WORD_W-1:0] kill);
    logic [WORD_W-1:0] s;
    logic c;
    c = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (kill[i]) c = 1'b0;
      s[i] = a[i] ^ b[i] ^ c;
      c = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
    end
    return s;
  endfunction

endpackage

// File: rtl/csa3Part.sv
module csa3Part
  import addTreePkg::*;
(
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] bIn,
  input  logic [WORD_W-1:0] cIn,
  input  logic [WORD_W-1:0] killMask,
  output logic [WORD_W-1:0] sumO,
  output logic [WORD_W-1:0] carryO
);
  logic [WORD_W-1:0] maj;

  assign sumO   = aIn ^ bIn ^ cIn;
  assign maj    = (aIn & bIn) | (aIn & cIn) | (bIn & cIn);
  // Shift carries one place up; drop those landing on an active cut and the top one
  assign carryO = {maj[WORD_W-2:0], 1'b0} & ~killMask;
endmodule

// File: rtl/addTreeCtl.sv
module addTreeCtl
  import addTreePkg::*;
#(
  parameter int                DEPTH    = 6,
  parameter logic [MASK_W-1:0] REG_MASK = '0,
  parameter int                CUT_LO   = 4,
  parameter int                CUT_HI   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cutLo,
  input  logic                   cutHi,
  output ctlStrobe_t [DEPTH:0]   ctlLvl
);
  ctlStrobe_t base;

  always_comb begin
    base.killMask         = '0;
    base.killMask[CUT_LO] = cutLo;
    base.killMask[CUT_HI] = cutHi;
  end

  // Cut settings follow the same register points as the operands
  for (genvar k = 0; k <= DEPTH; k++) begin : gStage
    ctlStrobe_t prev;
    ctlStrobe_t cur;

    if (k == 0) begin : gHead
      assign prev = base;
    end else begin : gLink
      assign prev = gStage[k-1].cur;
    end

    if (REG_MASK[k]) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cur <= '0;
        else       cur <= prev;
      end
    end else begin : gWire
      assign cur = prev;
    end

    assign ctlLvl[k] = cur;
  end
endmodule

// File: rtl/addTreeData.sv
module addTreeData
  import addTreePkg::*;
#(
  parameter int                NUM_IN   = 15,
  parameter int                DEPTH    = 6,
  parameter int                MAXOP    = 15,
  parameter int                IN_W     = 240,
  parameter logic [MASK_W-1:0] REG_MASK = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IN_W-1:0]       dataIn,
  input  ctlStrobe_t [DEPTH:0]  ctlLvl,
  output logic [WORD_W-1:0]     sumOut
);
  for (genvar k = 0; k <= DEPTH; k++) begin : gLvl
    logic [WORD_W-1:0] inOps [MAXOP];
    logic [WORD_W-1:0] ops   [MAXOP];

    if (k == 0) begin : gLoad
      for (genvar j = 0; j < MAXOP; j++) begin : gSlot
        if (j < NUM_IN) begin : gUsed
          assign inOps[j] = dataIn[j*WORD_W +: WORD_W];
        end else begin : gPad
          assign inOps[j] = '0;
        end
      end
    end else begin : gCmp
      localparam int IC = opsAt(NUM_IN, k-1);
      localparam int G  = IC / 3;
      localparam int R  = IC % 3;
      localparam int OC = opsAt(NUM_IN, k);

      for (genvar g = 0; g < G; g++) begin : gCsa
        csa3Part uCsa (
          .aIn     (gLvl[k-1].ops[3*g]),
          .bIn     (gLvl[k-1].ops[3*g+1]),
          .cIn     (gLvl[k-1].ops[3*g+2]),
          .killMask(ctlLvl[k-1].killMask),
          .sumO    (inOps[2*g]),
          .carryO  (inOps[2*g+1])
        );
      end
      for (genvar r = 0; r < R; r++) begin : gPass
        assign inOps[2*G+r] = gLvl[k-1].ops[3*G+r];
      end
      for (genvar j = OC; j < MAXOP; j++) begin : gIdle
        assign inOps[j] = '0;
      end
    end

    if (REG_MASK[k]) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int j = 0; j < MAXOP; j++) ops[j] <= '0;
        end else begin
          for (int j = 0; j < MAXOP; j++) ops[j] <= inOps[j];
        end
      end
    end else begin : gWire
      assign ops = inOps;
    end
  end

  logic [WORD_W-1:0] sumComb;
  assign sumComb = laneAdd(gLvl[DEPTH].ops[0], gLvl[DEPTH].ops[1],
                           ctlLvl[DEPTH].killMask);

  if (REG_MASK[DEPTH+1]) begin : gOutReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sumOut <= '0;
      else       sumOut <= sumComb;
    end
  end else begin : gOutWire
    assign sumOut = sumComb;
  end
endmodule

// File: rtl/partAddTree.sv
module partAddTree
  import addTreePkg::*;
#(
  parameter int                NUM_IN   = 15,
  parameter logic [MASK_W-1:0] REG_MASK = 8'b1000_0101,
  parameter int                CUT_LO   = 4,
  parameter int                CUT_HI   = 8,
  localparam int               IN_W     = ((NUM_IN < 1) ? 1 : NUM_IN) * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cutLo,
  input  logic              cutHi,
  input  logic [IN_W-1:0]   dataIn,
  output logic [WORD_W-1:0] sumOut
);
  localparam int DEPTH = depthOf(NUM_IN);
  localparam int MAXOP = slotsOf(NUM_IN);

  ctlStrobe_t [DEPTH:0] ctlLvl;

  addTreeCtl #(
    .DEPTH   (DEPTH),
    .REG_MASK(REG_MASK),
    .CUT_LO  (CUT_LO),
    .CUT_HI  (CUT_HI)
  ) uCtl (
    .clk   (clk),
    .rstN  (rstN),
    .cutLo (cutLo),
    .cutHi (cutHi),
    .ctlLvl(ctlLvl)
  );

  addTreeData #(
    .NUM_IN  (NUM_IN),
    .DEPTH   (DEPTH),
    .MAXOP   (MAXOP),
    .IN_W    (IN_W),
    .REG_MASK(REG_MASK)
  ) uData (
    .clk   (clk),
    .rstN  (rstN),
    .dataIn(dataIn),
    .ctlLvl(ctlLvl),
    .sumOut(sumOut)
  );
endmodule

// File: rtl/partAddTreeChk.sv
module partAddTreeChk
  import addTreePkg::*;
#(
  parameter int                NUM_IN   = 15,
  parameter logic [MASK_W-1:0] REG_MASK = '0,
  parameter int                IN_W     = 240
) (
  input logic              clk,
  input logic              rstN,
  input logic              cutLo,
  input logic              cutHi,
  input logic [IN_W-1:0]   dataIn,
  input logic [WORD_W-1:0] sumOut
);
  localparam int LAT = latencyOf(NUM_IN, REG_MASK);

  logic [IN_W+1:0] curIn;
  logic [IN_W+1:0] lastIn;
  logic [3:0]      runLen;
  logic            steady;
  logic            steadyHold;

  assign curIn = {cutLo, cutHi, dataIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastIn <= '0;
      runLen <= '0;
    end else begin
      lastIn <= curIn;
      if (curIn == lastIn) runLen <= (runLen == 4'hF) ? runLen : runLen + 4'd1;
      else                 runLen <= '0;
    end
  end

  // Inputs unchanged across the whole latency window (and one cycle more for hold)
  assign steady     = (LAT == 0) || ((curIn == lastIn) && (int'(runLen) >= LAT - 1));
  assign steadyHold = (curIn == lastIn) && (int'(runLen) >= LAT);

  function automatic logic [7:0] fieldSum(input logic [IN_W-1:0] d, input int lo, input int w);
    logic [7:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_IN; i++) acc = acc + 8'((d >> (i*WORD_W + lo)) & ((1 << w) - 1));
    return acc;
  endfunction

  logic [3:0] lowNib;
  logic [7:0] lowByte;
  logic [3:0] midNib;
  assign lowNib  = fieldSum(dataIn, 0, 4)[3:0];
  assign lowByte = fieldSum(dataIn, 0, 8);
  assign midNib  = fieldSum(dataIn, 4, 4)[3:0];

  // R2: the bottom nibble never receives a carry from below, in any cut setting
  a_r2_low_nibble: assert property (@(posedge clk) disable iff (!rstN)
    steady |-> (sumOut[3:0] == lowNib));

  // R4: with only the upper cut, the low byte wraps on its own
  a_r4_low_byte: assert property (@(posedge clk) disable iff (!rstN)
    (steady && cutHi && !cutLo) |-> (sumOut[7:0] == lowByte));

  // R5: with both cuts, bits 7:4 form an isolated lane
  a_r5_mid_lane: assert property (@(posedge clk) disable iff (!rstN)
    (steady && cutHi && cutLo) |-> (sumOut[7:4] == midNib));

  // R6: all-zero operands give zero
  a_r6_zero_sum: assert property (@(posedge clk) disable iff (!rstN)
    (steady && dataIn == '0) |-> (sumOut == '0));

  // R8: held inputs for longer than the latency give a held output
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    steadyHold |-> $stable(sumOut));
endmodule

bind partAddTree partAddTreeChk #(
  .NUM_IN  (NUM_IN),
  .REG_MASK(REG_MASK),
  .IN_W    (IN_W)
) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .cutLo (cutLo),
  .cutHi (cutHi),
  .dataIn(dataIn),
  .sumOut(sumOut)
);

// File: tb/partAddTree_tb.sv
module partAddTree_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NIN        = 15;
  localparam int BUS_W      = NIN * 16;
  localparam int LAT_MAIN   = 3;   // mask bits 0, 2 and 7 (output point for depth 6)
  localparam int LAT_ONE    = 1;   // output register only
  localparam int HIST       = 4096;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cutLo = 1'b0;
  logic             cutHi = 1'b0;
  logic [BUS_W-1:0] busIn = '0;
  logic [15:0]      outMain;
  logic [15:0]      outOne;
  logic [15:0]      outZero;

  int checks = 0;
  int errors = 0;
  int t = 0;

  logic [15:0] expHist  [HIST];
  logic [15:0] wordHist [HIST];
  string       tagHist  [HIST];

  always #(CLK_PERIOD/2) clk = ~clk;

  partAddTree #(.NUM_IN(NIN), .REG_MASK(8'b1000_0101)) u_dut (
    .clk(clk), .rstN(rstN), .cutLo(cutLo), .cutHi(cutHi),
    .dataIn(busIn), .sumOut(outMain));

  partAddTree #(.NUM_IN(1), .REG_MASK(8'b0000_0010)) uOne (
    .clk(clk), .rstN(rstN), .cutLo(cutLo), .cutHi(cutHi),
    .dataIn(busIn[15:0]), .sumOut(outOne));

  partAddTree #(.NUM_IN(0), .REG_MASK(8'b0000_0000)) uZero (
    .clk(clk), .rstN(rstN), .cutLo(cutLo), .cutHi(cutHi),
    .dataIn(busIn[15:0]), .sumOut(outZero));

  // Lane sums from the requirements: lanes chosen by the two cut bits
  function automatic logic [15:0] model(input logic [BUS_W-1:0] v, input logic c4, input logic c8);
    logic [15:0] masks [3];
    int          nm;
    logic [15:0] res;
    logic [15:0] acc;
    if (c4 && c8)  begin masks = '{16'hFF00, 16'h00F0, 16'h000F}; nm = 3; end
    else if (c4)   begin masks = '{16'hFFF0, 16'h000F, 16'h0000}; nm = 2; end
    else if (c8)   begin masks = '{16'hFF00, 16'h00FF, 16'h0000}; nm = 2; end
    else           begin masks = '{16'hFFFF, 16'h0000, 16'h0000}; nm = 1; end
    res = '0;
    for (int m = 0; m < nm; m++) begin
      acc = '0;
      for (int i = 0; i < NIN; i++) acc = acc + (v[i*16 +: 16] & masks[m]);
      res = res | (acc & masks[m]);
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s t=%0d got 0x%h expected 0x%h", tag, t, got, exp);
    end
  endtask

  task automatic step(input logic [BUS_W-1:0] v, input logic c4, input logic c8, input string tag);
    @(negedge clk);
    check((t >= LAT_MAIN) ? tagHist[t-LAT_MAIN] : "R8 latency",
          outMain, (t >= LAT_MAIN) ? expHist[t-LAT_MAIN] : 16'h0000);
    check("R7 single operand", outOne, (t >= LAT_ONE) ? wordHist[t-LAT_ONE] : 16'h0000);
    busIn = v;
    cutLo = c4;
    cutHi = c8;
    expHist[t]  = model(v, c4, c8);
    wordHist[t] = v[15:0];
    tagHist[t]  = tag;
    #1;
    check("R6 no operands", outZero, 16'h0000);
    t++;
  endtask

  function automatic logic [BUS_W-1:0] makeVec(input int key);
    logic [BUS_W-1:0] v;
    for (int i = 0; i < NIN; i++) begin
      case (key)
        0:       v[i*16 +: 16] = 16'h0000;
        1:       v[i*16 +: 16] = 16'hFFFF;
        2:       v[i*16 +: 16] = 16'h0111;
        3:       v[i*16 +: 16] = 16'h8888;
        default: v[i*16 +: 16] = 16'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired got running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string modeTag [4];
    modeTag = '{"R2 no cuts", "R3 cut at 4", "R4 cut at 8", "R5 both cuts"};

    // R1: registers hold zero during reset even with live operands
    busIn = makeVec(1);
    cutLo = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset main", outMain, 16'h0000);
    check("R1 reset single", outOne, 16'h0000);
    busIn = '0;
    cutLo = 1'b0;
    rstN  = 1'b1;

    // Sweep every cut mode over fixed and random operand patterns (first vector nonzero for R8)
    for (int mode = 0; mode < 4; mode++) begin
      for (int key = 0; key < 8; key++) begin
        step(makeVec((key + 1) % 8), mode[0], mode[1], modeTag[mode]);
      end
    end

    // R5: carry-heavy pattern that would cross both cuts if not cleared
    step({NIN{16'h0F0F}}, 1'b1, 1'b1, "R5 carry isolation");
    step({NIN{16'hFFFF}}, 1'b1, 1'b1, "R5 carry isolation");

    // R9: cut settings change every cycle alongside random operands
    for (int n = 0; n < 300; n++) begin
      step(makeVec(4), 1'($urandom), 1'($urandom), "R9 cut tracking");
    end

    // R6: flush with all-zero operands (held, so the checker also sees a steady window)
    for (int n = 0; n < LAT_MAIN + 4; n++) begin
      step('0, 1'b0, 1'b1, "R6 zero operands");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule